// File: doc/BRIEF.md
# Multi-channel memory-clear register block

This block is a 64-bit register window placed in front of up to eight external memory channels. Software reads one status word. That word shows, for every channel, whether the channel has finished initialising, whether its calibration failed, and whether a memory clear is still running. The init and calibration flags come from another clock domain, so each one passes through a two-flop synchroniser before it reaches the status word.

The second word has two uses, chosen by the `REVISION` parameter. In revision 0 it is a control register. Its low byte holds write-only triggers that start a memory clear on a channel, and its upper bits are plain read/write storage. A read of that word shows the low four bits of the channel-present map in place of the triggers. In any later revision the same word is a read-only capability register that shows the full eight-bit present map, and the clear function is not offered.

Each accepted trigger sends a one-cycle request to that channel's clear engine and sets the channel's busy flag. The flag drops when the engine answers with a done pulse. Software finds out that a clear has finished by polling the busy flag.

Top module: `memclr_csr`

## Requirements
- R1: The status word at byte offset 0x08 holds the synchronised init-done flag of channel n in bit n, its calibration-fail flag in bit 8+n and its clear-busy flag in bit 16+n. All other bits read 0. An input change that lands just before edge k is not yet shown by a read accepted at edge k+1, and is shown by a read accepted at edge k+3.
- R2: `req_ready` is always 1. A read accepted at an edge gives `rsp_valid` high with the data for exactly the following cycle. A write gives no `rsp_valid`.
- R3: In revision 0, a write to offset 0x10 with bit n set, where channel n is present and not busy, gives `clear_req[n]` high for exactly the one cycle after the write edge. The busy flag of that channel is set from that same edge.
- R4: In revision 0, a read of offset 0x10 returns the last written bits [63:8], zeros in bits [7:4] and `chan_present[3:0]` in bits [3:0]. The trigger values never read back.
- R5: A busy flag clears at the edge where that channel's `clear_done` is sampled high. A `clear_done` on an idle channel has no effect.
- R6: A trigger bit for a channel whose present bit is 0, or whose busy flag is already set, produces no `clear_req` and leaves that channel's busy flag unchanged.
- R7: When `REVISION` is above 0, a read of offset 0x10 returns `chan_present` in bits [7:0] and zeros above. Writes to that offset never raise `clear_req` and change no read value.
- R8: A read of any offset other than 0x08 and 0x10 returns 0, and a write to such an offset changes no register.
- R9: Synchronous reset clears the read/write control bits, every busy flag, every `clear_req` and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always 1; accesses are taken every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 64 | Read data |
| chan_present | input | NUM_CH | Channel-present map |
| mem_init_done | input | NUM_CH | Per-channel init-done flag, asynchronous |
| mem_cal_fail | input | NUM_CH | Per-channel calibration-fail flag, asynchronous |
| clear_req | output | NUM_CH | One-cycle clear request per channel |
| clear_done | input | NUM_CH | Clear-finished pulse per channel |

## Verification
The bench drives its inputs on the falling edge and samples on the next falling edge after the active edge. Read data, `rsp_valid` and the `clear_req` pulse therefore appear one cycle after the access that causes them. Two things are checked after a write: that `clear_req` is high in the sample right after the write edge, and that it is low again one cycle later. A busy flag set by a trigger is visible to the very next read, and a `clear_done` pulse has taken effect by the next read. Flag inputs pass through two synchroniser flops, so a read issued at once must still show the old value, while the read after it must show the new one. The random phase waits three cycles after any flag change before it compares the status word.

// File: rtl/memclr_pkg.sv
package memclr_pkg;

    localparam int unsigned WORD_W     = 64;
    localparam int unsigned MAX_CH     = 8;
    localparam int unsigned OFFSET_W   = 16;
    localparam logic [OFFSET_W-1:0] OFF_STATUS = 16'h0008;
    localparam logic [OFFSET_W-1:0] OFF_CTRL   = 16'h0010;

    // status word field bases; channel n sits at base + n
    localparam int unsigned ST_INIT_LSB = 0;
    localparam int unsigned ST_CAL_LSB  = 8;
    localparam int unsigned ST_BUSY_LSB = 16;
    localparam int unsigned CTRL_RW_LSB = 8;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CTRL   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [MAX_CH-1:0] init_done;
        logic [MAX_CH-1:0] cal_fail;
        logic [MAX_CH-1:0] busy;
    } chan_flags_t;

    function automatic reg_sel_e decode_offset(input logic [OFFSET_W-1:0] off);
        if (off == OFF_STATUS) return SEL_STATUS;
        if (off == OFF_CTRL)   return SEL_CTRL;
        return SEL_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input chan_flags_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ST_INIT_LSB +: MAX_CH] = f.init_done;
        w[ST_CAL_LSB  +: MAX_CH] = f.cal_fail;
        w[ST_BUSY_LSB +: MAX_CH] = f.busy;
        return w;
    endfunction

endpackage

// File: rtl/memclr_sync.sv
module memclr_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/memclr_chan.sv
module memclr_chan (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic present,
    input  logic allow,
    input  logic done,
    output logic req,
    output logic busy
);
    logic accept;

    assign accept = trig & present & allow & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            busy <= 1'b0;
        end else begin
            req <= accept;
            if (accept)
                busy <= 1'b1;
            else if (done)
                busy <= 1'b0;
        end
    end

    // R3: request is a single-cycle pulse, raised together with busy
    assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    assert_req_with_busy_R3: assert property (@(posedge clk) disable iff (rst)
        req |-> busy);
    // R5: done on a busy channel clears it on the next edge
    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);
    // R6: an absent channel never gets a request
    assert_absent_no_req_R6: assert property (@(posedge clk) disable iff (rst)
        !present |=> !req);
    // R6: a busy channel stays busy without a new request unless done
    assert_busy_no_retrig_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && !req));
endmodule

// File: rtl/memclr_csr.sv
module memclr_csr
    import memclr_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned REVISION = 0,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    input  logic [NUM_CH-1:0] chan_present,
    input  logic [NUM_CH-1:0] mem_init_done,
    input  logic [NUM_CH-1:0] mem_cal_fail,
    output logic [NUM_CH-1:0] clear_req,
    input  logic [NUM_CH-1:0] clear_done
);
    localparam bit          CLEAR_ON = (REVISION == 0);
    localparam int unsigned MAP_BITS = CLEAR_ON ? 4 : 8;
    localparam logic [MAX_CH-1:0] MAP_MASK = MAX_CH'((1 << MAP_BITS) - 1);
    localparam int unsigned RW_W     = WORD_W - CTRL_RW_LSB;

    logic [NUM_CH-1:0] init_s;
    logic [NUM_CH-1:0] cal_s;
    logic [NUM_CH-1:0] busy;
    logic [RW_W-1:0]   ctrl_rw;
    reg_sel_e          sel;
    logic              wr_ctrl;
    chan_flags_t       flags;
    logic [MAX_CH-1:0] pres8;
    logic [WORD_W-1:0] ctrl_word;
    logic [WORD_W-1:0] rd_word;

    assign req_ready = 1'b1;
    assign sel       = decode_offset(OFFSET_W'(req_addr));
    assign wr_ctrl   = CLEAR_ON && req_valid && req_write && (sel == SEL_CTRL);

    memclr_sync #(.WIDTH(NUM_CH)) u_sync_init (
        .clk(clk), .rst(rst), .async_in(mem_init_done), .sync_out(init_s));
    memclr_sync #(.WIDTH(NUM_CH)) u_sync_cal (
        .clk(clk), .rst(rst), .async_in(mem_cal_fail), .sync_out(cal_s));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        memclr_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .trig    (wr_ctrl && req_wdata[ch]),
            .present (chan_present[ch]),
            .allow   (CLEAR_ON),
            .done    (clear_done[ch]),
            .req     (clear_req[ch]),
            .busy    (busy[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_rw <= '0;
        else if (wr_ctrl)
            ctrl_rw <= req_wdata[WORD_W-1:CTRL_RW_LSB];
    end

    always_comb begin
        flags = '0;
        flags.init_done[NUM_CH-1:0] = init_s;
        flags.cal_fail[NUM_CH-1:0]  = cal_s;
        flags.busy[NUM_CH-1:0]      = busy;
        pres8 = '0;
        pres8[NUM_CH-1:0] = chan_present;
        ctrl_word = '0;
        if (CLEAR_ON)
            ctrl_word[WORD_W-1:CTRL_RW_LSB] = ctrl_rw;
        ctrl_word[MAX_CH-1:0] = pres8 & MAP_MASK;
        unique case (sel)
            SEL_STATUS: rd_word = pack_status(flags);
            SEL_CTRL:   rd_word = ctrl_word;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= rd_word;
        end
    end

    // R2: one-cycle read latency, no response to writes
    assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);
    assert_no_rsp_on_write_R2: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_write) |=> !rsp_valid);
    // R8: unmapped reads return zero
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && sel == SEL_NONE) |=> (rsp_rdata == '0));
    // R7: later revisions never issue a clear request
    assert_rev_no_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !CLEAR_ON |-> (clear_req == '0));
endmodule

// File: tb/memclr_csr_tb.sv
module memclr_csr_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  chan_present = 8'hB7;
    logic [7:0]  mem_init_done = '0;
    logic [7:0]  mem_cal_fail = '0;
    logic [7:0]  clear_done = '0;

    logic        req_ready, rsp_valid, b_ready, b_rsp_valid;
    logic [63:0] rsp_rdata, b_rsp_rdata;
    logic [7:0]  clear_req, b_clear_req;

    int total = 0;
    int bad = 0;
    logic b_req_seen = 1'b0;

    logic [63:0] rd0, rd1;
    logic        rv;
    logic [7:0]  wq0, wq1;
    logic        wrv;

    logic [55:0] exp_rw = '0;
    logic [7:0]  exp_busy = '0;

    always #10 clk = ~clk;

    memclr_csr #(.NUM_CH(8), .REVISION(0), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .chan_present(chan_present),
        .mem_init_done(mem_init_done), .mem_cal_fail(mem_cal_fail),
        .clear_req(clear_req), .clear_done(clear_done));

    memclr_csr #(.NUM_CH(8), .REVISION(1), .ADDR_W(8)) u_dut_rev1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(b_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(b_rsp_valid), .rsp_rdata(b_rsp_rdata), .chan_present(chan_present),
        .mem_init_done(mem_init_done), .mem_cal_fail(mem_cal_fail),
        .clear_req(b_clear_req), .clear_done(clear_done));

    always @(posedge clk) if (!rst && b_clear_req != 8'h00) b_req_seen = 1'b1;

    function automatic logic [63:0] ctrl0_exp();
        return {exp_rw, 4'h0, chan_present[3:0]};
    endfunction

    function automatic logic [63:0] ctrl1_exp();
        return {56'h0, chan_present};
    endfunction

    function automatic logic [63:0] stat_exp(input logic [7:0] i, input logic [7:0] c,
                                             input logic [7:0] b);
        return {40'h0, b, c, i};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        wq0 = clear_req; wq1 = b_clear_req; wrv = rsp_valid;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd0 = rsp_rdata; rd1 = b_rsp_rdata; rv = rsp_valid;
        req_valid = 1'b0;
    endtask

    task automatic pulse_done(input logic [7:0] m);
        @(negedge clk);
        clear_done = m;
        @(posedge clk);
        @(negedge clk);
        clear_done = '0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_rw = '0; exp_busy = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state, R4 ctrl readback, R1 status zero
        chk("R9 clear_req after reset", {56'h0, clear_req}, 64'h0);
        do_read(8'h10);
        chk("R9 R4 ctrl after reset", rd0, ctrl0_exp());
        chk("R2 rsp_valid on read", {63'h0, rv}, 64'h1);
        chk("R2 req_ready", {63'h0, req_ready}, 64'h1);
        do_read(8'h08);
        chk("R9 R1 status after reset", rd0, 64'h0);

        // R3 trigger on channel 0, R2 no response on write
        do_write(8'h10, 64'hABCD_0000_0000_1201);
        exp_rw = 56'hABCD_0000_0000_12; exp_busy = 8'h01;
        chk("R3 clear_req pulse", {56'h0, wq0}, 64'h01);
        chk("R2 no rsp on write", {63'h0, wrv}, 64'h0);
        @(negedge clk);
        chk("R3 clear_req one cycle", {56'h0, clear_req}, 64'h0);
        do_read(8'h10);
        chk("R4 ctrl hides triggers", rd0, ctrl0_exp());
        do_read(8'h08);
        chk("R3 busy set", rd0, stat_exp(8'h0, 8'h0, exp_busy));

        // R6 retrigger busy channel, absent channel 3
        do_write(8'h10, 64'h0000_0000_0000_0009);
        exp_rw = '0;
        chk("R6 busy and absent ignored", {56'h0, wq0}, 64'h0);
        do_read(8'h08);
        chk("R6 busy unchanged", rd0, stat_exp(8'h0, 8'h0, 8'h01));

        // R5 done on idle channel then on busy channel
        pulse_done(8'h02);
        do_read(8'h08);
        chk("R5 idle done no effect", rd0, stat_exp(8'h0, 8'h0, 8'h01));
        pulse_done(8'h01);
        exp_busy = 8'h00;
        do_read(8'h08);
        chk("R5 busy cleared", rd0, 64'h0);

        // R1 synchroniser delay
        mem_init_done = 8'hA5; mem_cal_fail = 8'h3C;
        do_read(8'h08);
        chk("R1 sync not yet visible", rd0, 64'h0);
        do_read(8'h08);
        chk("R1 sync visible", rd0, stat_exp(8'hA5, 8'h3C, 8'h00));
        chk("R7 R1 rev1 status", rd1, stat_exp(8'hA5, 8'h3C, 8'h00));

        // R7 revision above 0
        do_write(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_rw = 56'hFF_FFFF_FFFF_FFFF; exp_busy = chan_present;
        chk("R7 rev1 no clear_req", {56'h0, wq1}, 64'h0);
        chk("R3 multi-channel trigger", {56'h0, wq0}, {56'h0, chan_present});
        do_read(8'h10);
        chk("R7 rev1 capability", rd1, ctrl1_exp());
        chk("R4 ctrl all ones", rd0, ctrl0_exp());
        pulse_done(8'hFF);
        exp_busy = '0;

        // R8 unmapped offsets
        do_write(8'h18, 64'h1234_5678_9ABC_DEF0);
        chk("R8 unmapped write no trigger", {56'h0, wq0}, 64'h0);
        do_read(8'h18);
        chk("R8 unmapped read", rd0, 64'h0);
        do_read(8'h00);
        chk("R8 offset 0 read", rd0, 64'h0);
        do_read(8'h10);
        chk("R8 ctrl unchanged", rd0, ctrl0_exp());

        // random phase
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0, 1: begin
                    logic [63:0] d;
                    logic [7:0]  acc;
                    d = {$urandom, $urandom};
                    acc = d[7:0] & chan_present & ~exp_busy;
                    do_write(8'h10, d);
                    chk("R3 R6 random trigger", {56'h0, wq0}, {56'h0, acc});
                    chk("R7 random rev1 no req", {56'h0, wq1}, 64'h0);
                    exp_busy |= acc;
                    exp_rw = d[63:8];
                end
                2: begin
                    do_read(8'h10);
                    chk("R4 random ctrl", rd0, ctrl0_exp());
                    chk("R7 random capability", rd1, ctrl1_exp());
                end
                3: begin
                    do_read(8'h08);
                    chk("R1 random status", rd0, stat_exp(mem_init_done, mem_cal_fail, exp_busy));
                    chk("R7 random rev1 status", rd1, stat_exp(mem_init_done, mem_cal_fail, 8'h0));
                end
                4: begin
                    logic [7:0] m;
                    m = 8'($urandom);
                    pulse_done(m);
                    exp_busy &= ~m;
                end
                default: begin
                    logic [7:0] a;
                    a = 8'($urandom) & 8'hF8;
                    if (a == 8'h08 || a == 8'h10) a = 8'h20;
                    if ($urandom % 2 == 0) begin
                        do_write(a, {$urandom, $urandom});
                        chk("R8 random unmapped write", {56'h0, wq0}, 64'h0);
                    end else begin
                        do_read(a);
                        chk("R8 random unmapped read", rd0, 64'h0);
                    end
                    @(negedge clk);
                    mem_init_done = 8'($urandom); mem_cal_fail = 8'($urandom);
                    repeat (3) @(negedge clk);
                end
            endcase
        end

        // R9 reset while busy
        do_write(8'h10, 64'h5555_0000_0000_00FF);
        apply_reset();
        chk("R9 clear_req cleared", {56'h0, clear_req}, 64'h0);
        repeat (3) @(negedge clk);
        do_read(8'h08);
        chk("R9 busy cleared", rd0, stat_exp(mem_init_done, mem_cal_fail, 8'h0));
        do_read(8'h10);
        chk("R9 ctrl cleared", rd0, ctrl0_exp());

        chk("R7 rev1 never requested", {63'h0, b_req_seen}, 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule